// File: doc/BRIEF.md
# Four-Channel DAC Serial Control Front End

This block is the digital side of a four-channel digital-to-analog converter that is programmed over a three-wire serial port. A word is framed by an active-low frame line. Its bits arrive most significant first and are taken on each falling edge of the serial clock. After sixteen bits the block writes the data field, plus a range-doubling flag and a reference-buffer flag, into the staging register of the channel named by the top two bits.

Staging registers reach the outputs only while the active-low load line is held low. All four channels can therefore be prepared one at a time and then switched together. An active-low clear input zeroes every stored value without waiting for a clock.

The three serial-port lines and the load line are brought into the system clock domain through two-flop synchronizers. Serial clock edges are detected in that domain. The code width `RES` may be 8, 10 or 12.

Top module: `qdac_serial_frontend`

## Requirements
- R1: A frame holds 16 bits, sent most significant bit first. Each bit is sampled on a falling edge of `ser_clk` while `frame_n` is low.
- R2: Word bits 15:14 select the channel: 00 is channel 0, 01 is channel 1, 10 is channel 2 and 11 is channel 3. Channel c appears on `dac_code[c*RES +: RES]`.
- R3: Word bit 13 is stored as the range-doubling flag of the addressed channel and appears on `gain_sel[c]`, where 1 means doubled range.
- R4: Word bit 12 is stored as the reference-buffer flag of the addressed channel and appears on `ref_buf[c]`, where 1 means buffered.
- R5: The code is left-justified in word bits 11 down to 12-RES. Any lower bits are ignored. The code is straight binary.
- R6: Falling edges after the 16th in a frame are ignored. A new frame is accepted only after `frame_n` has gone high and then low again.
- R7: If `frame_n` rises before the 16th falling edge, the frame is dropped and no staging register changes.
- R8: Outputs stay unchanged while `load_n` is high. While `load_n` is low, every channel's outputs copy that channel's staging register.
- R9: While `zero_n` is low, all staging and output registers are zero. The outputs clear asynchronously, without a clock edge.
- R10: Synchronous `rst` zeroes all staging and output registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Active-low frame enable for the serial port |
| ser_clk | input | 1 | Serial clock; data is taken on its falling edge |
| ser_data | input | 1 | Serial data, MSB first |
| load_n | input | 1 | Active-low level copy from staging registers to outputs |
| zero_n | input | 1 | Active-low asynchronous clear of all registers |
| dac_code | output | 4*RES | Output codes, channel c in bits c*RES +: RES |
| gain_sel | output | 4 | Per-channel range-doubling flag |
| ref_buf | output | 4 | Per-channel reference-buffer flag |

## Verification
Staging registers cannot be observed directly. Every write is therefore followed by a load pulse, so that written values, ignored bits, aborted frames and cleared values can all be read at the outputs. The aborted and over-long frames are the hardest cases. The bench drives frames cut off after 10 and after 15 edges, and frames that carry four extra edges with conflicting bits. For each, it compares the outputs after the next load with a model in which only complete 16-bit prefixes count. The asynchronous clear is checked one nanosecond after `zero_n` falls, between clock edges.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int NCH     = 4;
  localparam int ADDR_W  = 2;
  localparam int FRAME_W = 16;
  localparam int CTRL_W  = 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic gain;
    logic bufen;
  } chan_cfg_t;
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int          WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/qdac_shifter.sv
module qdac_shifter
  import qdac_pkg::*;
#(
  parameter int RES = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  frame_s,
  input  logic                  sclk_s,
  input  logic                  sdat_s,
  output logic                  wr_en,
  output logic [CTRL_W+RES-1:0] word,
  output logic [CNT_W-1:0]      bit_cnt
);
  logic [FRAME_W-1:0] shreg;
  logic               sclk_q;
  logic               done;
  logic               fall;

  assign fall = sclk_q & ~sclk_s;
  assign word = shreg[FRAME_W-1 -: CTRL_W+RES];

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      sclk_q  <= 1'b1;
      done    <= 1'b0;
      wr_en   <= 1'b0;
      bit_cnt <= '0;
    end else begin
      sclk_q <= sclk_s;
      wr_en  <= 1'b0;
      if (frame_s) begin
        bit_cnt <= '0;
        done    <= 1'b0;
      end else if (fall && !done) begin
        shreg   <= {shreg[FRAME_W-2:0], sdat_s};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == CNT_W'(FRAME_W - 1)) begin
          done  <= 1'b1;
          wr_en <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/qdac_regbank.sv
module qdac_regbank
  import qdac_pkg::*;
#(
  parameter int RES = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  zero_n,
  input  logic                  wr_en,
  input  logic [CTRL_W+RES-1:0] word,
  input  logic                  load_go,
  output logic [NCH*RES-1:0]    dac_code,
  output logic [NCH-1:0]        gain_sel,
  output logic [NCH-1:0]        ref_buf
);
  localparam int TOP = CTRL_W + RES - 1;

  logic [ADDR_W-1:0] wr_addr;
  chan_cfg_t         wr_cfg;
  logic [RES-1:0]    wr_code;

  assign wr_addr = word[TOP -: ADDR_W];
  assign wr_cfg  = '{gain: word[RES+1], bufen: word[RES]};
  assign wr_code = word[RES-1:0];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [RES-1:0] stage_code, out_code;
    chan_cfg_t      stage_cfg, out_cfg;

    always_ff @(posedge clk or negedge zero_n) begin
      if (!zero_n) begin
        stage_code <= '0;
        stage_cfg  <= '0;
        out_code   <= '0;
        out_cfg    <= '0;
      end else if (rst) begin
        stage_code <= '0;
        stage_cfg  <= '0;
        out_code   <= '0;
        out_cfg    <= '0;
      end else begin
        if (wr_en && wr_addr == ADDR_W'(c)) begin
          stage_code <= wr_code;
          stage_cfg  <= wr_cfg;
        end
        if (load_go) begin
          out_code <= stage_code;
          out_cfg  <= stage_cfg;
        end
      end
    end

    assign dac_code[c*RES +: RES] = out_code;
    assign gain_sel[c]            = out_cfg.gain;
    assign ref_buf[c]             = out_cfg.bufen;
  end
endmodule

// File: rtl/qdac_serial_frontend.sv
module qdac_serial_frontend
  import qdac_pkg::*;
#(
  parameter int RES = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_n,
  input  logic               ser_clk,
  input  logic               ser_data,
  input  logic               load_n,
  input  logic               zero_n,
  output logic [4*RES-1:0]   dac_code,
  output logic [3:0]         gain_sel,
  output logic [3:0]         ref_buf
);
  logic [3:0]            sync_q;
  logic                  frame_s, sclk_s, sdat_s, load_s;
  logic                  wr_en;
  logic [CTRL_W+RES-1:0] word;
  logic [CNT_W-1:0]      bit_cnt;

  qdac_sync #(.WIDTH(4), .RST_VAL(4'b1101)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({frame_n, ser_clk, ser_data, load_n}),
    .q   (sync_q)
  );
  assign {frame_s, sclk_s, sdat_s, load_s} = sync_q;

  qdac_shifter #(.RES(RES)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .frame_s (frame_s),
    .sclk_s  (sclk_s),
    .sdat_s  (sdat_s),
    .wr_en   (wr_en),
    .word    (word),
    .bit_cnt (bit_cnt)
  );

  qdac_regbank #(.RES(RES)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .zero_n   (zero_n),
    .wr_en    (wr_en),
    .word     (word),
    .load_go  (~load_s),
    .dac_code (dac_code),
    .gain_sel (gain_sel),
    .ref_buf  (ref_buf)
  );
endmodule

// File: rtl/qdac_checker.sv
module qdac_checker #(
  parameter int RES = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             zero_n,
  input logic             frame_s,
  input logic             load_s,
  input logic             wr_en,
  input logic [4:0]       bit_cnt,
  input logic [4*RES-1:0] dac_code,
  input logic [3:0]       gain_sel,
  input logic [3:0]       ref_buf
);
  // R9
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !zero_n |-> (dac_code == '0 && gain_sel == '0 && ref_buf == '0));

  // R8
  hold_out_chk: assert property (@(posedge clk) disable iff (rst || !zero_n)
    ($past(load_s) && $past(zero_n)) |-> ($stable(dac_code) && $stable(gain_sel) && $stable(ref_buf)));

  // R6
  one_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= 5'd16);

  // R7
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    frame_s |=> !wr_en);
endmodule

bind qdac_serial_frontend qdac_checker #(.RES(RES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .zero_n   (zero_n),
  .frame_s  (frame_s),
  .load_s   (load_s),
  .wr_en    (wr_en),
  .bit_cnt  (bit_cnt),
  .dac_code (dac_code),
  .gain_sel (gain_sel),
  .ref_buf  (ref_buf)
);

// File: tb/test_qdac_serial_frontend.sv
`timescale 1ns/1ps
module test_qdac_serial_frontend;
  localparam int RES  = 10;
  localparam int HALF = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_n = 1'b1, ser_clk = 1'b1, ser_data = 1'b0, load_n = 1'b1, zero_n = 1'b1;
  logic [4*RES-1:0] dac_code;
  logic [3:0]       gain_sel, ref_buf;

  int total = 0, fails = 0;
  logic [RES-1:0] st_code [4], ex_code [4];
  logic           st_g [4], st_b [4], ex_g [4], ex_b [4];

  always #5 clk = ~clk;

  qdac_serial_frontend #(.RES(RES)) i_qdac_serial_frontend (
    .clk(clk), .rst(rst), .frame_n(frame_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .load_n(load_n), .zero_n(zero_n), .dac_code(dac_code), .gain_sel(gain_sel), .ref_buf(ref_buf)
  );

  function automatic logic [15:0] mk(input logic [1:0] ch, input logic g, input logic b,
                                     input logic [RES-1:0] code);
    logic [15:0] w;
    w = 16'({ch, g, b, code}) << (12 - RES);
    w = w | 16'((1 << (12 - RES)) - 1);  // R5: ignored low bits set to 1
    return w;
  endfunction

  task automatic send(input logic [15:0] w, input int edges, input logic extra);
    frame_n = 1'b0;
    #(HALF);
    for (int i = 0; i < edges; i++) begin
      ser_data = (i < 16) ? w[15-i] : extra;
      #(HALF) ser_clk = 1'b0;
      #(HALF) ser_clk = 1'b1;
    end
    #(HALF) frame_n = 1'b1;
    #(2*HALF);
  endtask

  task automatic stage(input logic [15:0] w);
    int c;
    c = int'(w[15:14]);
    st_g[c]    = w[13];
    st_b[c]    = w[12];
    st_code[c] = w[11 -: RES];
  endtask

  task automatic pulse_load();
    load_n = 1'b0;
    #60 load_n = 1'b1;
    #60;
    for (int c = 0; c < 4; c++) begin
      ex_code[c] = st_code[c]; ex_g[c] = st_g[c]; ex_b[c] = st_b[c];
    end
  endtask

  task automatic check(input string req);
    logic [4*RES-1:0] ec;
    logic [3:0] eg, eb;
    for (int c = 0; c < 4; c++) begin
      ec[c*RES +: RES] = ex_code[c]; eg[c] = ex_g[c]; eb[c] = ex_b[c];
    end
    total++;
    if (dac_code !== ec || gain_sel !== eg || ref_buf !== eb) begin
      fails++;
      $display("FAIL %s: code=%h gain=%b buf=%b expected code=%h gain=%b buf=%b",
               req, dac_code, gain_sel, ref_buf, ec, eg, eb);
    end
  endtask

  task automatic zero_model();
    for (int c = 0; c < 4; c++) begin
      st_code[c] = '0; st_g[c] = 1'b0; st_b[c] = 1'b0;
      ex_code[c] = '0; ex_g[c] = 1'b0; ex_b[c] = 1'b0;
    end
  endtask

  initial begin
    #1_000_000;
    fails++; total++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [RES-1:0] cd;
    logic [15:0] w;
    zero_model();
    #100 rst = 1'b0;
    #20;
    check("R10 reset state");

    // R2 R3 R4 R5 R1: sweep all channels, gain/buffer combos and codes
    for (int ch = 0; ch < 4; ch++) begin
      for (int k = 0; k < 16; k++) begin
        cd = (k == 15) ? '1 : RES'((k * 67 + ch * 29) % (1 << RES));
        w  = mk(2'(ch), k[0], k[1], cd);
        send(w, 16, 1'b0);
        stage(w);
        pulse_load();
        check("R2 R3 R4 R5 sweep");
      end
    end

    // R8: staged but not loaded stays hidden
    w = mk(2'd1, 1'b1, 1'b0, RES'(12'h155));
    send(w, 16, 1'b0);
    stage(w);
    check("R8 hold before load");
    w = mk(2'd3, 1'b0, 1'b1, RES'(12'h0AA));
    send(w, 16, 1'b0);
    stage(w);
    check("R8 hold two staged");
    pulse_load();
    check("R8 simultaneous load");

    // R7: aborted frames after 10 and 15 edges
    send(mk(2'd1, 1'b0, 1'b1, RES'(12'h3C3)), 10, 1'b0);
    pulse_load();
    check("R7 abort at 10 edges");
    send(mk(2'd2, 1'b1, 1'b1, '1), 15, 1'b0);
    pulse_load();
    check("R7 abort at 15 edges");

    // R6: extra edges with conflicting bits ignored
    w = mk(2'd0, 1'b1, 1'b1, RES'(12'h2A5));
    send(w, 20, 1'b1);
    stage(w);
    pulse_load();
    check("R6 extra edges ones");
    w = mk(2'd2, 1'b0, 1'b0, '1);
    send(w, 20, 1'b0);
    stage(w);
    pulse_load();
    check("R6 extra edges zeros");
    w = mk(2'd2, 1'b1, 1'b0, RES'(12'h011));
    send(w, 16, 1'b0);
    stage(w);
    pulse_load();
    check("R6 new frame after toggle");

    // R9: asynchronous clear, checked between clock edges
    w = mk(2'd3, 1'b1, 1'b1, RES'(12'h1F0));
    send(w, 16, 1'b0);
    stage(w);
    @(posedge clk); #2 zero_n = 1'b0;
    #1;
    zero_model();
    check("R9 async clear immediate");
    #50 zero_n = 1'b1;
    #20;
    pulse_load();
    check("R9 staging cleared");

    // R10: synchronous reset clears staged and output values
    w = mk(2'd1, 1'b1, 1'b1, RES'(12'h0F0));
    send(w, 16, 1'b0);
    stage(w);
    pulse_load();
    check("R1 pre-reset load");
    w = mk(2'd0, 1'b1, 1'b0, RES'(12'h077));
    send(w, 16, 1'b0);
    rst = 1'b1;
    #30 rst = 1'b0;
    #20;
    zero_model();
    check("R10 reset clears outputs");
    pulse_load();
    check("R10 reset clears staging");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule